// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block produces the column address for each beat of a DDR2-style read or write burst. A mode write selects a burst length of four or eight beats and an ordering of sequential or interleaved. A burst request then supplies a starting column. From the next cycle the block puts out one column per cycle, with a valid flag and a flag on the final beat. The low column bits are permuted according to the selected length and ordering, and the higher bits are held at their starting value for the whole burst.

For eight-beat bursts, sequential ordering wraps inside the four-column group that holds the start, then visits the other group of four at the same offset. Interleaved ordering XORs the beat number into the start address. A burst cannot be stopped or interrupted. A request that arrives while a burst is running is dropped and flagged. A request presented on the final beat is taken at once, so bursts can follow each other with no idle cycle.

The request side is valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high when the block is idle and on the final beat of a burst. A request shown while `req_ready` is low is not held or queued: it is discarded and `req_rej` pulses on the next cycle. The beat output has no back-pressure, because a DRAM burst cannot pause once it has started.

Top module: `burst_colseq`

## Requirements
- R1: After reset, `beat_valid`, `req_rej` and `mode_err` are low and `req_ready` is high. The setting is four beats with sequential ordering.
- R2: A mode write with `mode_len` = 3'b010 selects four beats and 3'b011 selects eight beats. `mode_ord` = 0 selects sequential ordering and 1 selects interleaved. When the block is idle, the write takes effect for requests from the next cycle on.
- R3: A mode write with any other `mode_len` code pulses `mode_err` on the next cycle and leaves both length and ordering unchanged.
- R4: A four-beat sequential burst puts out low bits (s+k) mod 4 for beat k, where s is start bits [1:0]. Start 1 gives 1,2,3,0.
- R5: A four-beat interleaved burst puts out low bits s XOR k. Start 1 gives 1,0,3,2. In four-beat bursts, start bit 2 does not affect the order and is passed through unchanged.
- R6: An eight-beat sequential burst wraps inside the starting group of four and then covers the other group of four at the same offset. Start 1 gives 1,2,3,0,5,6,7,4 and start 6 gives 6,7,4,5,2,3,0,1.
- R7: An eight-beat interleaved burst puts out start[2:0] XOR k. Start 5 gives 5,4,7,6,1,0,3,2.
- R8: Column bits above bit 2 (above bit 1 for four-beat bursts) equal the start column on every beat.
- R9: The first beat appears the cycle after acceptance. There is one beat per cycle with `beat_valid` continuously high, and `beat_last` is high on the final beat only. A burst always runs to its full length.
- R10: While a burst is running and not on its final beat, `req_ready` is low. A request shown then is dropped, `req_rej` pulses on the next cycle, and the running burst is unchanged.
- R11: A request accepted on the final beat starts its first beat on the very next cycle.
- R12: A legal mode write made while a burst is running is held. The running burst keeps its length and ordering, and the held setting takes effect once no burst follows seamlessly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Mode write strobe |
| mode_len | input | 3 | Burst length code (3'b010 = 4, 3'b011 = 8) |
| mode_ord | input | 1 | Ordering: 0 sequential, 1 interleaved |
| req_valid | input | 1 | Burst request valid |
| req_ready | output | 1 | Request can be taken this cycle |
| req_col | input | COL_W | Starting column of the request |
| req_rej | output | 1 | Pulses the cycle after a dropped request |
| beat_valid | output | 1 | A beat column is presented |
| beat_col | output | COL_W | Column address of the current beat |
| beat_last | output | 1 | Current beat is the final beat of the burst |
| mode_err | output | 1 | Pulses the cycle after a reserved length code |

## Verification
Two events can fall in the same cycle here. A mode write can coincide with a burst boundary: it can arrive during a burst, or alongside an idle acceptance. A new request can coincide with the final beat of the running burst. The bench writes a new length on the second beat of a four-beat burst and confirms that the burst still ends after four beats and that the next burst uses eight. It also writes a mode in the same cycle as an idle acceptance and confirms that the accepted burst used the old setting. Seamless chaining is provoked by holding a request on the final beat and checking that the next cycle already shows the first column of the new burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int MAX_BEATS = 8;
  localparam int CNT_W = $clog2(MAX_BEATS);
  localparam logic [2:0] LEN_CODE4 = 3'b010;
  localparam logic [2:0] LEN_CODE8 = 3'b011;

  typedef enum logic {ORD_SEQ = 1'b0, ORD_INTLV = 1'b1} ord_t;

  typedef struct packed {
    logic len8;
    ord_t ord;
  } bmode_t;
endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] len_code,
  input  logic       ord_bit,
  input  logic       busy,
  input  logic       finish,
  output bmode_t     cur,
  output logic       err
);
  bmode_t pend, newm;
  logic   pend_v, code_ok, wr_ok;

  always_comb begin
    code_ok   = (len_code == LEN_CODE4) || (len_code == LEN_CODE8);
    wr_ok     = wr && code_ok;
    newm.len8 = (len_code == LEN_CODE8);
    newm.ord  = ord_t'(ord_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '{len8: 1'b0, ord: ORD_SEQ};
      pend   <= '{len8: 1'b0, ord: ORD_SEQ};
      pend_v <= 1'b0;
      err    <= 1'b0;
    end else begin
      err <= wr && !code_ok;
      if (finish) begin
        if (wr_ok)       cur <= newm;
        else if (pend_v) cur <= pend;
        pend_v <= 1'b0;
      end else if (wr_ok) begin
        if (busy) begin
          pend   <= newm;
          pend_v <= 1'b1;
        end else begin
          cur <= newm;
        end
      end
    end
  end

  // R3
  reserved_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !code_ok && !busy) |=> ($stable(cur) && err));

  // R12
  busy_write_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && busy && !finish) |=> $stable(cur));
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [COL_W-1:0] req_col,
  input  bmode_t           cur,
  output logic             req_ready,
  output logic             req_rej,
  output logic             active,
  output logic [CNT_W-1:0] cnt,
  output logic [COL_W-1:0] base,
  output bmode_t           run,
  output logic             last,
  output logic             finish
);
  logic             accept;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx  = run.len8 ? CNT_W'(MAX_BEATS - 1) : CNT_W'(MAX_BEATS / 2 - 1);
    last      = active && (cnt == last_idx);
    req_ready = !active || last;
    accept    = req_valid && req_ready;
    finish    = last && !accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      cnt     <= '0;
      base    <= '0;
      run     <= '{len8: 1'b0, ord: ORD_SEQ};
      req_rej <= 1'b0;
    end else begin
      req_rej <= req_valid && !req_ready;
      if (accept) begin
        active <= 1'b1;
        cnt    <= '0;
        base   <= req_col;
        run    <= cur;
      end else if (last) begin
        active <= 1'b0;
        cnt    <= '0;
      end else if (active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9
  runs_to_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (active && cnt == $past(cnt) + 1'b1 && $stable(base)));

  // R10
  busy_request_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last && req_valid) |=> req_rej);

  // R11
  seamless_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && req_valid) |=> (active && cnt == '0));
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base,
  input  logic [CNT_W-1:0] cnt,
  input  bmode_t           run,
  output logic [COL_W-1:0] col
);
  localparam int KEEP_W = COL_W - 3;

  logic [1:0] lo2;
  logic       nib;

  always_comb begin
    if (run.ord == ORD_INTLV) lo2 = base[1:0] ^ cnt[1:0];
    else                      lo2 = base[1:0] + cnt[1:0];
    nib = run.len8 ? (base[2] ^ cnt[2]) : base[2];
  end

  generate
    if (KEEP_W > 0) begin : g_upper
      assign col = {base[COL_W-1:3], nib, lo2};
    end else begin : g_narrow
      assign col = {nib, lo2};
    end
  endgenerate
endmodule

// File: rtl/burst_colseq.sv
module burst_colseq
  import burst_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [2:0]       mode_len,
  input  logic             mode_ord,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [COL_W-1:0] req_col,
  output logic             req_rej,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_last,
  output logic             mode_err
);
  bmode_t           cur, run;
  logic             active, finish, last;
  logic [CNT_W-1:0] cnt;
  logic [COL_W-1:0] base;

  burst_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .len_code(mode_len),
    .ord_bit(mode_ord), .busy(active), .finish(finish),
    .cur(cur), .err(mode_err)
  );

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_col(req_col),
    .cur(cur), .req_ready(req_ready), .req_rej(req_rej), .active(active),
    .cnt(cnt), .base(base), .run(run), .last(last), .finish(finish)
  );

  burst_order_gen #(.COL_W(COL_W)) u_order (
    .base(base), .cnt(cnt), .run(run), .col(beat_col)
  );

  assign beat_valid = active;
  assign beat_last  = last;

  // R8
  upper_bits_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_last) |=> $stable(beat_col[COL_W-1:3]));

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> req_ready);
endmodule

// File: tb/sim_burst_colseq.sv
module sim_burst_colseq;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             mode_wr = 1'b0;
  logic [2:0]       mode_len = 3'b010;
  logic             mode_ord = 1'b0;
  logic             req_valid = 1'b0;
  logic [COL_W-1:0] req_col = '0;
  logic             req_ready, req_rej, beat_valid, beat_last, mode_err;
  logic [COL_W-1:0] beat_col;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_colseq #(.COL_W(COL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_len(mode_len),
    .mode_ord(mode_ord), .req_valid(req_valid), .req_ready(req_ready),
    .req_col(req_col), .req_rej(req_rej), .beat_valid(beat_valid),
    .beat_col(beat_col), .beat_last(beat_last), .mode_err(mode_err)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(int s, bit len8, bit intlv, int k);
    int grp, off;
    off = s % 4;
    if (!len8) begin
      if (intlv) return (s - off) + (off ^ k);
      return (s - off) + ((off + k) % 4);
    end
    if (intlv) return (s - s % 8) + ((s % 8) ^ k);
    grp = ((s / 4) + (k / 4)) % 2;
    return (s - s % 8) + 4 * grp + ((off + k) % 4);
  endfunction

  task automatic set_mode(logic [2:0] len, logic ord);
    @(negedge clk);
    mode_wr = 1'b1; mode_len = len; mode_ord = ord;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  // Presents a request at a negedge; returns at the negedge where beat 0 is visible.
  task automatic start_req(int s, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_col = COL_W'(s);
    check({tag, " ready before start"}, int'(req_ready), 1);
    @(negedge clk);
  endtask

  // Checks all beats. rej_at: beat on which a stray request is shown (-1 none).
  // follow: request on the final beat. mw_at: beat on which a mode write is made.
  task automatic expect_beats(int s, bit len8, bit intlv, string tag,
                              int rej_at, bit follow, int fcol,
                              int mw_at, logic [2:0] mw_len, logic mw_ord);
    int n;
    n = len8 ? 8 : 4;
    for (int k = 0; k < n; k++) begin
      check({tag, " valid"}, int'(beat_valid), 1);
      check({tag, " col"}, int'(beat_col), exp_col(s, len8, intlv, k));
      check({tag, " last"}, int'(beat_last), (k == n - 1) ? 1 : 0);
      if (rej_at >= 0 && k == rej_at + 1)
        check({tag, " R10 reject flag"}, int'(req_rej), 1);
      req_valid = 1'b0;
      mode_wr = 1'b0;
      if (k == rej_at) begin
        req_valid = 1'b1; req_col = ~COL_W'(s);
        check({tag, " R10 ready low"}, int'(req_ready), 0);
      end
      if (follow && k == n - 1) begin
        req_valid = 1'b1; req_col = COL_W'(fcol);
        check({tag, " R11 ready on last"}, int'(req_ready), 1);
      end
      if (k == mw_at) begin
        mode_wr = 1'b1; mode_len = mw_len; mode_ord = mw_ord;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    mode_wr = 1'b0;
    if (!follow) check({tag, " idle after"}, int'(beat_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 valid", int'(beat_valid), 0);
    check("R1 ready", int'(req_ready), 1);
    check("R1 rej", int'(req_rej), 0);
    check("R1 err", int'(mode_err), 0);
    start_req('h081, "R1 default");
    expect_beats('h081, 1'b0, 1'b0, "R1 default", -1, 1'b0, 0, -1, 3'b0, 1'b0);
  endtask

  task automatic t_len4();
    set_mode(3'b010, 1'b0);
    start_req('h2B5, "R4 R8 seq4");
    expect_beats('h2B5, 1'b0, 1'b0, "R4 R8 seq4", -1, 1'b0, 0, -1, 3'b0, 1'b0);
    set_mode(3'b010, 1'b1);
    start_req('h2B5, "R5 R2 int4");
    expect_beats('h2B5, 1'b0, 1'b1, "R5 R2 int4", -1, 1'b0, 0, -1, 3'b0, 1'b0);
    start_req('h102, "R5 int4 b");
    expect_beats('h102, 1'b0, 1'b1, "R5 int4 b", -1, 1'b0, 0, -1, 3'b0, 1'b0);
  endtask

  task automatic t_len8();
    set_mode(3'b011, 1'b0);
    start_req('h151, "R6 R2 seq8 s1");
    expect_beats('h151, 1'b1, 1'b0, "R6 R2 seq8 s1", -1, 1'b0, 0, -1, 3'b0, 1'b0);
    start_req('h3F6, "R6 R8 seq8 s6");
    expect_beats('h3F6, 1'b1, 1'b0, "R6 R8 seq8 s6", -1, 1'b0, 0, -1, 3'b0, 1'b0);
    set_mode(3'b011, 1'b1);
    start_req('h0A5, "R7 int8 s5");
    expect_beats('h0A5, 1'b1, 1'b1, "R7 int8 s5", -1, 1'b0, 0, -1, 3'b0, 1'b0);
  endtask

  task automatic t_reserved();
    @(negedge clk);
    mode_wr = 1'b1; mode_len = 3'b101; mode_ord = 1'b0;
    @(negedge clk);
    mode_wr = 1'b0;
    check("R3 err pulse", int'(mode_err), 1);
    @(negedge clk);
    check("R3 err clears", int'(mode_err), 0);
    start_req('h0E3, "R3 setting kept");
    expect_beats('h0E3, 1'b1, 1'b1, "R3 setting kept", -1, 1'b0, 0, -1, 3'b0, 1'b0);
  endtask

  task automatic t_reject();
    set_mode(3'b010, 1'b0);
    start_req('h046, "R10 busy");
    expect_beats('h046, 1'b0, 1'b0, "R10 busy", 1, 1'b0, 0, -1, 3'b0, 1'b0);
    check("R10 no extra burst", int'(beat_valid), 0);
  endtask

  task automatic t_seamless();
    start_req('h010, "R11 first");
    expect_beats('h010, 1'b0, 1'b0, "R11 first", -1, 1'b1, 'h1C5, -1, 3'b0, 1'b0);
    expect_beats('h1C5, 1'b0, 1'b0, "R11 second", -1, 1'b0, 0, -1, 3'b0, 1'b0);
  endtask

  task automatic t_defer();
    start_req('h209, "R12 running");
    expect_beats('h209, 1'b0, 1'b0, "R12 running", -1, 1'b0, 0, 1, 3'b011, 1'b0);
    start_req('h20E, "R12 applied");
    expect_beats('h20E, 1'b1, 1'b0, "R12 applied", -1, 1'b0, 0, -1, 3'b0, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_col = 'h133;
    mode_wr = 1'b1; mode_len = 3'b010; mode_ord = 1'b1;
    @(negedge clk);
    mode_wr = 1'b0;
    expect_beats('h133, 1'b1, 1'b0, "R12 R2 same cycle", -1, 1'b0, 0, -1, 3'b0, 1'b0);
    start_req('h133, "R2 new setting");
    expect_beats('h133, 1'b0, 1'b1, "R2 new setting", -1, 1'b0, 0, -1, 3'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_len4();
    t_len8();
    t_reserved();
    t_reject();
    t_seamless();
    t_defer();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule